// File: doc/BRIEF.md
# Bidirectional GPIO Port Register Bank

This block holds the registers of one 8-pin general-purpose I/O port and presents them on a simple register bus. Three registers are reachable. The direction register sets each pin as an input or an output. The output latch holds the value driven onto output pins. The pin-level view returns what the pads actually carry, after synchronization. Per pin, the block produces a drive value and an output enable, and it takes in a sampled pad level.

Two mask inputs change how pins read and drive. An analog-select vector hides the digital level of pins used as converter inputs. Only pins 0-3 and pin 5 can be analog. An oscillator-mode flag claims the two top pins: they read as zero in every register, and they are never driven. Reading the pin level and reading the latch are deliberately different operations. Read-modify-write sequences use the latch, so external loading on a pin cannot corrupt them.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset the direction register reads 8'hFF, the latch reads 8'h00, pad_oe is 8'h00 and bus_rdata is 8'h00.
- R2: Writing the direction register (address 2) sets pad_oe to the bitwise inverse of the written value from the next cycle on (bit 1 = input, driver off). Enabled pins drive the latch bit on pad_out. Reading address 2 returns the stored value.
- R3: A write to the pin address (address 0) updates the output latch, and so does a write to the latch address (address 1). A later read of address 1 returns the written value.
- R4: A read of the latch address returns the latched value regardless of the levels on pad_in.
- R5: A read of address 0 returns pad_in as passed through two synchronizing flops. A level held for two clock edges before the edge that captures the read strobe is returned.
- R6: In an address-0 read, each pin whose ana_sel bit is set and that lies in mask 8'h2F (pins 0-3 and 5) reads as 0. ana_sel bits 4, 6 and 7 have no effect. ana_sel never changes pad_oe.
- R7: While osc_mode is 1, bits 7:6 read as 0 from addresses 0, 1 and 2, and pad_oe[7:6] and pad_out[7:6] are 0. The stored bits are kept and reappear when osc_mode returns to 0.
- R8: Read data appears on bus_rdata one clock after the read strobe. A read and a write to the same register in the same cycle return the old value.
- R9: Address 3 reads as 8'h00, and writes to it change neither the direction register nor the latch.
- R10: bus_rdata holds its value in cycles without a read strobe, even when pad_in changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register select: 0 pin level, 1 latch, 2 direction, 3 unused |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pad_in | input | 8 | Sampled pad levels |
| pad_out | output | 8 | Drive value per pin |
| pad_oe | output | 8 | Output enable per pin, 1 = driving |
| ana_sel | input | 8 | Analog-select per pin (effective on pins 0-3, 5) |
| osc_mode | input | 1 | Oscillator claims pins 7:6 |

## Verification
Direction and latch writes reach pad_oe and pad_out one edge after the write strobe. The bench samples those pins at the falling edge that follows the write. Read data is due one edge after the strobe, and the bench always reads it at the falling edge after that. A change on pad_in needs two edges of synchronization before a PORT read strobe can capture it. The bench therefore waits two rising edges after it changes a pad and only then issues the strobe. The mask inputs act on the read multiplexer in the same cycle, so the bench sets them before the strobe edge.

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int W = 8,
  parameter int AW = 2,
  parameter logic [W-1:0] ANA_MASK = 8'h2F,
  parameter logic [W-1:0] OSC_MASK = 8'hC0,
  parameter logic [AW-1:0] A_PIN = 2'd0,
  parameter logic [AW-1:0] A_LAT = 2'd1,
  parameter logic [AW-1:0] A_DIR = 2'd2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  pad_in,
  output logic [W-1:0]  pad_out,
  output logic [W-1:0]  pad_oe,
  input  logic [W-1:0]  ana_sel,
  input  logic          osc_mode
);
  logic [W-1:0] dir_q, lat_q, s1_q, s2_q, rd_nxt;
  logic [W-1:0] keep;

  assign keep    = osc_mode ? ~OSC_MASK : '1;
  assign pad_oe  = ~dir_q & keep;
  assign pad_out = lat_q & keep;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dir_q <= '1;
      lat_q <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_DIR) dir_q <= bus_wdata;
      if (bus_addr == A_PIN || bus_addr == A_LAT) lat_q <= bus_wdata;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= pad_in;
      s2_q <= s1_q;
    end

  always_comb begin
    rd_nxt = '0;
    if (bus_addr == A_PIN)      rd_nxt = s2_q & ~(ana_sel & ANA_MASK);
    else if (bus_addr == A_LAT) rd_nxt = lat_q;
    else if (bus_addr == A_DIR) rd_nxt = dir_q;
    rd_nxt = rd_nxt & keep;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_nxt;
endmodule

module gpio_port_regs_chk #(
  parameter int W = 8,
  parameter int AW = 2,
  parameter logic [W-1:0] ANA_MASK = 8'h2F,
  parameter logic [W-1:0] OSC_MASK = 8'hC0,
  parameter logic [AW-1:0] A_PIN = 2'd0,
  parameter logic [AW-1:0] A_LAT = 2'd1,
  parameter logic [AW-1:0] A_DIR = 2'd2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [W-1:0]  bus_wdata,
  input logic [W-1:0]  bus_rdata,
  input logic [W-1:0]  pad_out,
  input logic [W-1:0]  pad_oe,
  input logic [W-1:0]  ana_sel,
  input logic          osc_mode,
  input logic [W-1:0]  lat_q
);
  p_dir_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_DIR && !osc_mode) |=> (osc_mode || pad_oe == ~$past(bus_wdata)));
  p_lat_rd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_LAT && !osc_mode) |=> bus_rdata == $past(lat_q));
  p_ana_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_PIN) |=> (bus_rdata & $past(ana_sel & ANA_MASK)) == '0);
  p_osc_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    osc_mode |-> ((pad_oe & OSC_MASK) == '0 && (pad_out & OSC_MASK) == '0));
  p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind gpio_port_regs gpio_port_regs_chk #(
  .W(W), .AW(AW), .ANA_MASK(ANA_MASK), .OSC_MASK(OSC_MASK),
  .A_PIN(A_PIN), .A_LAT(A_LAT), .A_DIR(A_DIR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_out(pad_out), .pad_oe(pad_oe),
  .ana_sel(ana_sel), .osc_mode(osc_mode), .lat_q(lat_q)
);

// File: tb/gpio_port_regs_test.sv
`timescale 1ns/1ps
module gpio_port_regs_test;
  logic clk = 0, rst_n = 0;
  logic [1:0] bus_addr = 0;
  logic bus_wr = 0, bus_rd = 0, osc_mode = 0;
  logic [7:0] bus_wdata = 0, pad_in = 0, ana_sel = 8'h2F;
  logic [7:0] bus_rdata, pad_out, pad_oe, got, prev;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  gpio_port_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .ana_sel(ana_sel), .osc_mode(osc_mode)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic pad(input logic [7:0] v);
    @(negedge clk); pad_in = v;
    repeat (2) @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 rdata", bus_rdata, 8'h00);
    chk("R1 oe", pad_oe, 8'h00);
    rd(2'd2, got); chk("R1 dir", got, 8'hFF);
    rd(2'd1, got); chk("R1 lat", got, 8'h00);
    pad(8'hFF);
    rd(2'd0, got); chk("R6 reset analog", got, 8'hD0);

    ana_sel = 8'h00;
    for (int v = 0; v < 256; v++) begin
      pad(v[7:0]); rd(2'd0, got); chk("R5 pin", got, v[7:0]);
    end

    pad(8'hFF);
    for (int a = 0; a < 256; a++) begin
      @(negedge clk); ana_sel = a[7:0];
      rd(2'd0, got); chk("R6 mask", got, 8'hFF & ~(a[7:0] & 8'h2F));
    end

    for (int v = 0; v < 256; v += 17) begin
      pad(~v[7:0]);
      wr(2'd0, v[7:0]); rd(2'd1, got); chk("R3 pin write", got, v[7:0]);
      wr(2'd1, ~v[7:0]); rd(2'd1, got); chk("R3 lat write", got, ~v[7:0]);
      pad(v[7:0]); rd(2'd1, got); chk("R4 lat vs pad", got, ~v[7:0]);
    end

    ana_sel = 8'h00;
    wr(2'd1, 8'hA5);
    for (int d = 0; d < 256; d++) begin
      wr(2'd2, d[7:0]);
      chk("R2 oe", pad_oe, ~d[7:0]);
      chk("R2 out", pad_out & pad_oe, 8'hA5 & ~d[7:0]);
      rd(2'd2, got); chk("R2 dir rd", got, d[7:0]);
    end
    ana_sel = 8'hFF; wr(2'd2, 8'h00);
    chk("R6 oe unaffected", pad_oe, 8'hFF);
    ana_sel = 8'h00;

    osc_mode = 1;
    wr(2'd1, 8'hFF);
    chk("R7 oe", pad_oe, 8'h3F);
    chk("R7 out", pad_out, 8'h3F);
    wr(2'd2, 8'hFF);
    rd(2'd2, got); chk("R7 dir", got, 8'h3F);
    rd(2'd1, got); chk("R7 lat", got, 8'h3F);
    pad(8'hFF); rd(2'd0, got); chk("R7 pin", got, 8'h3F);
    osc_mode = 0;
    rd(2'd1, got); chk("R7 lat kept", got, 8'hFF);
    rd(2'd2, got); chk("R7 dir kept", got, 8'hFF);

    wr(2'd1, 8'h3C);
    @(negedge clk); bus_addr = 2'd1; bus_wdata = 8'hC3; bus_wr = 1; bus_rd = 1;
    @(negedge clk); bus_wr = 0; bus_rd = 0;
    chk("R8 old value", bus_rdata, 8'h3C);
    rd(2'd1, got); chk("R8 new value", got, 8'hC3);

    wr(2'd3, 8'h55);
    rd(2'd3, got); chk("R9 read zero", got, 8'h00);
    rd(2'd2, got); chk("R9 dir kept", got, 8'hFF);
    rd(2'd1, got); chk("R9 lat kept", got, 8'hC3);

    rd(2'd1, prev);
    pad(8'h0F);
    repeat (4) @(negedge clk);
    chk("R10 hold", bus_rdata, prev);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule